// File: doc/BRIEF.md
# Rate Locked Loop Controller

This block closes a rate locked loop around an external voltage-controlled crystal oscillator. The loop recovers a clock, nominally 622.08 MHz, that follows the rate of data arriving into a clock-crossing FIFO. Once per frame row, on a row strobe that arrives about every 3 µs, the block samples the FIFO write and read pointers. It takes their modulo distance as the fill level and compares that with a target spacing. It then emits a train of "raise" or "lower" pulses on complementary output pairs. An external low-pass filter integrates these pulses into the oscillator's control voltage. The number of pulses in a train grows with the size of the error, so a larger rate mismatch pushes the oscillator harder.

The block also keeps a running balance of justification events. Every eight net negative events produce a one-cycle strobe that asks the write side to insert one extra word. Every eight net positive events produce a strobe that asks it to drop one word. The FIFO storage, the filter, the oscillator and the differential output buffers sit outside this block.

Top module: `rate_loop_ctrl`

## Requirements
- R1: The fill level is (wr_ptr - rd_ptr) modulo 64. It is captured only in a cycle where row_strobe is high. Pointer or target changes without a strobe cause no pulses.
- R2: The error is the fill level minus target. A positive error (FIFO filling) pulses the raise pair, and a negative error pulses the lower pair. The train holds min(|error|, 15) pulses.
- R3: An error with magnitude at or below deadband produces no pulses.
- R4: Each pulse is high for exactly 4 clocks, then low for 4 clocks. The first pulse goes high on the second clock edge after the edge that samples row_strobe.
- R5: raise_p and lower_p are never high together. raise_n is always the inverse of raise_p, and lower_n is always the inverse of lower_p.
- R6: A row strobe that arrives while a train is still running discards the rest of that train. Both outputs go low on the next edge, and a new train built from the new sample follows.
- R7: A cycle with neg_just high and pos_just low advances a 3-bit balance by one. When the balance wraps from 7 to 0, extra_word is high for exactly one cycle.
- R8: A cycle with pos_just high and neg_just low retreats the balance by one. When it wraps from 0 to 7, skip_word is high for exactly one cycle.
- R9: When pos_just and neg_just are high in the same cycle, the balance does not change and no strobe is produced.
- R10: A synchronous active-high rst clears the balance and any running train. It drives raise_p, lower_p, extra_word and skip_word low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_strobe | input | 1 | One-cycle marker at the end of each frame row |
| wr_ptr | input | 6 | FIFO write pointer |
| rd_ptr | input | 6 | FIFO read pointer |
| target | input | 6 | Desired pointer distance (32 is half depth) |
| deadband | input | 6 | Largest error magnitude that yields no pulses |
| pos_just | input | 1 | Positive justification event |
| neg_just | input | 1 | Negative justification event |
| raise_p | output | 1 | Raise-frequency pulse, true side |
| raise_n | output | 1 | Raise-frequency pulse, complement |
| lower_p | output | 1 | Lower-frequency pulse, true side |
| lower_n | output | 1 | Lower-frequency pulse, complement |
| extra_word | output | 1 | One-cycle request to insert a word |
| skip_word | output | 1 | One-cycle request to drop a word |

## Verification
The loop is driven with errors of zero, inside the deadband, just outside it, beyond the clamp, and with a read pointer numerically above the write pointer. Together these separate the direction choice, the deadband, the clamp and the modulo subtraction. Random pointer, target and deadband sets are compared against a bench model of pulse count and direction. A second strobe partway through a long raise train shows whether the old train is cut off and replaced. Random justification streams, including cycles with both events high, check the wrap strobes against a bench balance counter.

// File: rtl/rll_pkg.sv
package rll_pkg;
  typedef enum logic {DIR_LOWER = 1'b0, DIR_RAISE = 1'b1} steer_e;
endpackage

// File: rtl/rll_fill_sampler.sv
module rll_fill_sampler #(
  parameter int PTR_W      = 6,
  parameter int MAX_PULSES = 15,
  localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  input  logic [PTR_W-1:0]  target_i,
  input  logic [PTR_W-1:0]  deadband_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  count_o,
  output rll_pkg::steer_e   dir_o
);
  localparam logic [PTR_W:0] CLAMP = (PTR_W+1)'(MAX_PULSES);

  logic [PTR_W-1:0] fill;
  logic [PTR_W:0]   err;
  logic [PTR_W:0]   mag;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    fill = wr_ptr_i - rd_ptr_i;
    err  = {1'b0, fill} - {1'b0, target_i};
    mag  = err[PTR_W] ? (~err + 1'b1) : err;
    if (mag <= {1'b0, deadband_i})
      count_d = '0;
    else if (mag > CLAMP)
      count_d = CNT_W'(MAX_PULSES);
    else
      count_d = mag[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_o  <= 1'b0;
      count_o <= '0;
      dir_o   <= rll_pkg::DIR_LOWER;
    end else begin
      load_o <= strobe_i;
      if (strobe_i) begin
        count_o <= count_d;
        dir_o   <= err[PTR_W] ? rll_pkg::DIR_LOWER : rll_pkg::DIR_RAISE;
      end
    end
  end
endmodule

// File: rtl/rll_pulse_gen.sv
module rll_pulse_gen #(
  parameter int CNT_W   = 4,
  parameter int HI_CYC  = 4,
  parameter int LO_CYC  = 4,
  localparam int PERIOD = HI_CYC + LO_CYC,
  localparam int PH_W   = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  rll_pkg::steer_e  dir_i,
  output logic             raise_o,
  output logic             lower_o
);
  localparam logic [PH_W-1:0] HI_L   = PH_W'(HI_CYC);
  localparam logic [PH_W-1:0] LAST_L = PH_W'(PERIOD - 1);

  logic [CNT_W-1:0] remain;
  logic [PH_W-1:0]  phase;
  rll_pkg::steer_e  dir_q;
  logic             high_now;

  assign high_now = (remain != '0) && (phase < HI_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      phase   <= '0;
      dir_q   <= rll_pkg::DIR_LOWER;
      raise_o <= 1'b0;
      lower_o <= 1'b0;
    end else if (load_i) begin
      remain  <= count_i;
      phase   <= '0;
      dir_q   <= dir_i;
      raise_o <= 1'b0;
      lower_o <= 1'b0;
    end else begin
      raise_o <= high_now && (dir_q == rll_pkg::DIR_RAISE);
      lower_o <= high_now && (dir_q == rll_pkg::DIR_LOWER);
      if (remain != '0) begin
        if (phase == LAST_L) begin
          phase  <= '0;
          remain <= remain - 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rll_just_acc.sv
module rll_just_acc #(
  parameter int JUST_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pos_i,
  input  logic neg_i,
  output logic extra_o,
  output logic skip_o
);
  localparam logic [JUST_W-1:0] TOP = '1;

  logic [JUST_W-1:0] bal;

  always_ff @(posedge clk) begin
    if (rst) begin
      bal     <= '0;
      extra_o <= 1'b0;
      skip_o  <= 1'b0;
    end else begin
      extra_o <= 1'b0;
      skip_o  <= 1'b0;
      if (neg_i && !pos_i) begin
        bal     <= bal + 1'b1;
        extra_o <= (bal == TOP);
      end else if (pos_i && !neg_i) begin
        bal    <= bal - 1'b1;
        skip_o <= (bal == '0);
      end
    end
  end
endmodule

// File: rtl/rate_loop_ctrl.sv
module rate_loop_ctrl #(
  parameter int PTR_W      = 6,
  parameter int MAX_PULSES = 15,
  parameter int HI_CYC     = 4,
  parameter int LO_CYC     = 4,
  parameter int JUST_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_strobe,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [PTR_W-1:0] target,
  input  logic [PTR_W-1:0] deadband,
  input  logic             pos_just,
  input  logic             neg_just,
  output logic             raise_p,
  output logic             raise_n,
  output logic             lower_p,
  output logic             lower_n,
  output logic             extra_word,
  output logic             skip_word
);
  localparam int CNT_W = $clog2(MAX_PULSES + 1);

  logic             smp_load;
  logic [CNT_W-1:0] smp_count;
  rll_pkg::steer_e  smp_dir;
  logic             raise_q;
  logic             lower_q;

  rll_fill_sampler #(.PTR_W(PTR_W), .MAX_PULSES(MAX_PULSES)) sampler_i (
    .clk(clk), .rst(rst), .strobe_i(row_strobe),
    .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
    .target_i(target), .deadband_i(deadband),
    .load_o(smp_load), .count_o(smp_count), .dir_o(smp_dir)
  );

  rll_pulse_gen #(.CNT_W(CNT_W), .HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) pulses_i (
    .clk(clk), .rst(rst), .load_i(smp_load), .count_i(smp_count),
    .dir_i(smp_dir), .raise_o(raise_q), .lower_o(lower_q)
  );

  rll_just_acc #(.JUST_W(JUST_W)) just_i (
    .clk(clk), .rst(rst), .pos_i(pos_just), .neg_i(neg_just),
    .extra_o(extra_word), .skip_o(skip_word)
  );

  assign raise_p = raise_q;
  assign raise_n = ~raise_q;
  assign lower_p = lower_q;
  assign lower_n = ~lower_q;
endmodule

// File: rtl/rll_checker.sv
module rll_checker (
  input logic clk,
  input logic rst,
  input logic pos_just,
  input logic neg_just,
  input logic raise_p,
  input logic raise_n,
  input logic lower_p,
  input logic lower_n,
  input logic extra_word,
  input logic skip_word
);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(raise_p && lower_p));
  a_r5_raise_pair: assert property (@(posedge clk) disable iff (rst)
    raise_n == !raise_p);
  a_r5_lower_pair: assert property (@(posedge clk) disable iff (rst)
    lower_n == !lower_p);
  a_r7_extra_cause: assert property (@(posedge clk) disable iff (rst)
    extra_word |-> ($past(neg_just) && !$past(pos_just)));
  a_r8_skip_cause: assert property (@(posedge clk) disable iff (rst)
    skip_word |-> ($past(pos_just) && !$past(neg_just)));
  a_r7_extra_single: assert property (@(posedge clk) disable iff (rst)
    extra_word |=> !extra_word);
  a_r8_skip_single: assert property (@(posedge clk) disable iff (rst)
    skip_word |=> !skip_word);
  a_r9_no_both: assert property (@(posedge clk) disable iff (rst)
    !(extra_word && skip_word));
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !raise_p && !lower_p && !extra_word && !skip_word);
endmodule

bind rate_loop_ctrl rll_checker chk_i (
  .clk(clk), .rst(rst), .pos_just(pos_just), .neg_just(neg_just),
  .raise_p(raise_p), .raise_n(raise_n), .lower_p(lower_p), .lower_n(lower_n),
  .extra_word(extra_word), .skip_word(skip_word)
);

// File: tb/rate_loop_ctrl_tb_top.sv
`timescale 1ns/1ps
module rate_loop_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       row_strobe = 1'b0;
  logic [5:0] wr_ptr = '0, rd_ptr = '0, target = 6'd32, deadband = 6'd1;
  logic       pos_just = 1'b0, neg_just = 1'b0;
  logic       raise_p, raise_n, lower_p, lower_n, extra_word, skip_word;

  int checks = 0;
  int errors = 0;
  int rise_up = 0, rise_dn = 0;
  logic prev_up = 1'b0, prev_dn = 1'b0;
  int run_up = 0, run_dn = 0;
  bit width_on = 1'b1;

  always #10 clk = ~clk;

  rate_loop_ctrl dut_i (
    .clk(clk), .rst(rst), .row_strobe(row_strobe), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .target(target), .deadband(deadband),
    .pos_just(pos_just), .neg_just(neg_just),
    .raise_p(raise_p), .raise_n(raise_n), .lower_p(lower_p), .lower_n(lower_n),
    .extra_word(extra_word), .skip_word(skip_word)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pulse edges, widths, pairing (R4, R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (raise_p && !prev_up) begin rise_up++; run_up = 0; end
      if (lower_p && !prev_dn) begin rise_dn++; run_dn = 0; end
      if (raise_p) run_up++;
      if (lower_p) run_dn++;
      if (width_on && !raise_p && prev_up) chk("R4 raise width", run_up, 4);
      if (width_on && !lower_p && prev_dn) chk("R4 lower width", run_dn, 4);
      if (raise_p && lower_p) chk("R5 both high", 1, 0);
      if (raise_n == raise_p || lower_n == lower_p) chk("R5 pair", 0, 1);
      prev_up = raise_p;
      prev_dn = lower_p;
    end
  end

  function automatic int exp_count(logic [5:0] w, logic [5:0] r,
                                   logic [5:0] t, logic [5:0] d);
    int fill, e, m;
    fill = (int'(w) - int'(r) + 64) % 64;
    e = fill - int'(t);
    m = (e < 0) ? -e : e;
    if (m <= int'(d)) return 0;
    return (m > 15) ? 15 : m;
  endfunction

  function automatic bit exp_raise(logic [5:0] w, logic [5:0] r, logic [5:0] t);
    return ((int'(w) - int'(r) + 64) % 64) >= int'(t);
  endfunction

  task automatic strobe_and_clear(logic [5:0] w, logic [5:0] r,
                                  logic [5:0] t, logic [5:0] d);
    wr_ptr = w; rd_ptr = r; target = t; deadband = d;
    row_strobe = 1'b1;
    @(negedge clk);
    row_strobe = 1'b0;
    @(negedge clk);
    rise_up = 0; rise_dn = 0;
  endtask

  task automatic train(string req, logic [5:0] w, logic [5:0] r,
                       logic [5:0] t, logic [5:0] d);
    int n;
    bit up;
    n = exp_count(w, r, t, d);
    up = exp_raise(w, r, t);
    strobe_and_clear(w, r, t, d);
    repeat (126) @(negedge clk);
    chk({req, " raise count"}, rise_up, up ? n : 0);
    chk({req, " lower count"}, rise_dn, up ? 0 : n);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int m;
    int seen_x, seen_s, exp_x, exp_s;
    logic [2:0] bal;
    void'($urandom(32'h5eed_0611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 raise_p", int'(raise_p), 0);
    chk("R10 lower_p", int'(lower_p), 0);
    chk("R10 extra", int'(extra_word), 0);
    chk("R10 skip", int'(skip_word), 0);
    rst = 1'b0;
    @(negedge clk);

    // R4: first rising edge two edges after sampling edge
    wr_ptr = 6'd37; rd_ptr = 6'd0; target = 6'd32; deadband = 6'd1;
    row_strobe = 1'b1;
    @(negedge clk); row_strobe = 1'b0;
    chk("R4 low after load edge-1", int'(raise_p), 0);
    @(negedge clk);
    chk("R4 low at load edge", int'(raise_p), 0);
    @(negedge clk);
    chk("R4 high second edge", int'(raise_p), 1);
    repeat (60) @(negedge clk);

    train("R2 zero err R3", 6'd40, 6'd8, 6'd32, 6'd1);
    train("R3 inside deadband", 6'd33, 6'd0, 6'd32, 6'd1);
    train("R2 just outside", 6'd34, 6'd0, 6'd32, 6'd1);
    train("R3 deadband zero", 6'd33, 6'd0, 6'd32, 6'd0);
    train("R2 lower five", 6'd27, 6'd0, 6'd32, 6'd1);
    train("R2 clamp raise", 6'd63, 6'd0, 6'd10, 6'd1);
    train("R1 modulo wrap", 6'd3, 6'd60, 6'd32, 6'd1);
    train("R3 wide deadband", 6'd42, 6'd0, 6'd32, 6'd12);

    // R1: pointer/target changes without a strobe do nothing
    rise_up = 0; rise_dn = 0;
    for (int i = 0; i < 80; i++) begin
      wr_ptr = 6'($urandom); rd_ptr = 6'($urandom); target = 6'($urandom);
      @(negedge clk);
    end
    chk("R1 no strobe raise", rise_up, 0);
    chk("R1 no strobe lower", rise_dn, 0);

    // R6: restart mid-train
    strobe_and_clear(6'd47, 6'd0, 6'd32, 6'd1);
    repeat (30) @(negedge clk);
    width_on = 1'b0;
    strobe_and_clear(6'd29, 6'd0, 6'd32, 6'd1);
    chk("R6 outputs low after load", int'(raise_p) + int'(lower_p), 0);
    repeat (126) @(negedge clk);
    chk("R6 old train gone", rise_up, 0);
    chk("R6 new train", rise_dn, 3);
    width_on = 1'b1;

    // R2/R3: random sets against model
    for (int i = 0; i < 24; i++)
      train("R2 random", 6'($urandom), 6'($urandom), 6'($urandom), 6'($urandom_range(0, 4)));

    // R7: eight negative events
    exp_x = 0; seen_x = 0;
    for (int i = 0; i < 8; i++) begin
      neg_just = 1'b1;
      @(negedge clk);
      if (extra_word) seen_x++;
      if (i == 7) chk("R7 extra on eighth", int'(extra_word), 1);
    end
    neg_just = 1'b0;
    @(negedge clk);
    chk("R7 single cycle", int'(extra_word), 0);
    chk("R7 count", seen_x, 1);

    // R8: eight positive events from balance 0
    for (int i = 0; i < 8; i++) begin
      pos_just = 1'b1;
      @(negedge clk);
      if (i == 0) chk("R8 skip on first underflow", int'(skip_word), 1);
      else if (skip_word) chk("R8 spurious skip", 1, 0);
    end
    pos_just = 1'b0;
    @(negedge clk);
    // balance now 0 again; R9: both high does nothing
    for (int i = 0; i < 10; i++) begin
      pos_just = 1'b1; neg_just = 1'b1;
      @(negedge clk);
      chk("R9 both no strobe", int'(extra_word) + int'(skip_word), 0);
    end
    pos_just = 1'b1; neg_just = 1'b0;
    @(negedge clk);
    chk("R9 balance kept", int'(skip_word), 1);

    // R7/R8/R9 random stream against model (balance now 7)
    bal = 3'd7;
    seen_x = 0; seen_s = 0; exp_x = 0; exp_s = 0;
    for (int i = 0; i < 400; i++) begin
      m = $urandom_range(0, 3);
      pos_just = m[0]; neg_just = m[1];
      @(negedge clk);
      if (m == 2) begin if (bal == 3'd7) exp_x++; bal = bal + 3'd1; end
      else if (m == 1) begin if (bal == 3'd0) exp_s++; bal = bal - 3'd1; end
      if (extra_word) seen_x++;
      if (skip_word) seen_s++;
    end
    pos_just = 1'b0; neg_just = 1'b0;
    chk("R7 random extra", seen_x, exp_x);
    chk("R8 random skip", seen_s, exp_s);

    // R10: reset mid-train
    strobe_and_clear(6'd63, 6'd0, 6'd20, 6'd1);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears train", int'(raise_p), 0);
    rst = 1'b0;
    rise_up = 0;
    repeat (40) @(negedge clk);
    chk("R10 train stays cleared", rise_up, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule